// File: doc/BRIEF.md
# Spectrum Half-Swap Reorder Buffer

This block sits in front of an inverse transform in an OFDMA transmit chain. The frequency-domain generator upstream emits each symbol carrier by carrier in centred order, running from the most negative carrier -N/2 up to carrier N/2-1. The transform expects natural bin order, 0 through N-1. The buffer accepts one symbol per packet on a ready/valid sink and re-emits the same complex samples in transform order on a ready/valid source. On that source it also drives a start-of-symbol marker.

The symbol length N is chosen at run time from four sizes by a 2-bit code. The code is taken together with the first sample of each symbol. Storage is a two-bank memory that alternates between the banks: one symbol is written while the previous one is read out, so a steady stream passes with no gap between symbols. The half swap costs nothing in logic. Because N is a power of two, the write address is the arrival index with its top used bit inverted. Read-out is then a plain count.

Top module: `spec_swap_reorder`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid` and `out_sop` are 0.
- R2: The code on `size_sel` gives the symbol length N: 0 gives 128, 1 gives 512, 2 gives 1024 and 3 gives 2048. Exactly N samples are accepted and exactly N are emitted for each symbol.
- R3: Output positions 0 to N/2-1 of a symbol carry, in order, the samples received at arrival positions N/2 to N-1 of that symbol (carriers 0 to N/2-1).
- R4: Output positions N/2 to N-1 carry, in order, the samples received at arrival positions 0 to N/2-1 (carriers -N/2 to -1).
- R5: `out_sop` is 1 only while `out_valid` is 1, and only on output position 0 of each symbol.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with `out_re`, `out_im` and `out_sop` unchanged, and no sample is lost.
- R7: `size_sel` is sampled only with the first sample of a symbol. A change later in the symbol has no effect on the length or order of that symbol.
- R8: With `out_ready` held at 1, two symbols offered back to back are accepted with no cycle of `in_ready` low. Their 2N output samples leave on consecutive cycles.
- R9: When both banks hold a complete symbol that has not been read out, `in_ready` is 0. It returns to 1 once one of those symbols has been fully emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_sel | input | 2 | Symbol length code, taken with the first sample of each symbol |
| in_valid | input | 1 | Sink sample valid |
| in_ready | output | 1 | Sink can accept a sample |
| in_re | input | DW | Sink sample, real part |
| in_im | input | DW | Sink sample, imaginary part |
| out_valid | output | 1 | Source sample valid |
| out_ready | input | 1 | Downstream accepts a sample |
| out_re | output | DW | Source sample, real part |
| out_im | output | DW | Source sample, imaginary part |
| out_sop | output | 1 | First sample (bin 0) of a symbol |

## Verification
The bench goes after the half boundary in all four sizes. An address flip on the wrong bit, or a swap done in the wrong direction, shows up as a data mismatch at output position 0 or N/2.

A size code changed in the middle of a 128-sample symbol to the 2048 code tests when the length is taken. A design that re-reads the code would emit a truncated or extended symbol and leave samples pending or unexpected.

Random downstream stalls catch an output stage that moves, drops or duplicates a sample while held. Holding the output off until both banks fill checks that the sink stops, not that it overwrites a bank still waiting to be read. Two symbols sent back to back with the output always ready expose any idle cycle at the bank handover.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int NBANK = 2;

    typedef enum logic [1:0] {
        SZ_128  = 2'd0,
        SZ_512  = 2'd1,
        SZ_1024 = 2'd2,
        SZ_2048 = 2'd3
    } size_code_e;

    // log2 of the symbol length for each size code
    function automatic logic [3:0] code_to_log2(input logic [1:0] code);
        logic [3:0] lg;
        case (size_code_e'(code))
            SZ_128:  lg = 4'd7;
            SZ_512:  lg = 4'd9;
            SZ_1024: lg = 4'd10;
            default: lg = 4'd11;
        endcase
        return lg;
    endfunction

endpackage

// File: rtl/ssr_bank_flags.sv
module ssr_bank_flags
    import ssr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic                  set_bank,
    input  logic [3:0]            set_lg,
    input  logic                  clr_en,
    input  logic                  clr_bank,
    output logic [NBANK-1:0]      full,
    output logic [NBANK-1:0][3:0] bank_lg
);

    typedef struct packed {
        logic [NBANK-1:0]      full;
        logic [NBANK-1:0][3:0] lg;
    } flag_state_t;

    flag_state_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        for (int b = 0; b < NBANK; b++) begin
            if (set_en && (set_bank == 1'(b))) begin
                fl_d.full[b] = 1'b1;
                fl_d.lg[b]   = set_lg;
            end
            if (clr_en && (clr_bank == 1'(b))) begin
                fl_d.full[b] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign full    = fl_q.full;
    assign bank_lg = fl_q.lg;

    // A bank is never filled while it still holds an unread symbol
    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !fl_q.full[set_bank]);

    // Writer and reader never finish on the same bank in one cycle
    assert_bank_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && clr_en) |-> (set_bank != clr_bank));

endmodule

// File: rtl/ssr_writer.sv
module ssr_writer
    import ssr_pkg::*;
#(
    parameter int LOG2_NMAX = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           size_sel,
    input  logic                 in_valid,
    input  logic [NBANK-1:0]     bank_full,
    output logic                 in_ready,
    output logic                 wr_en,
    output logic [LOG2_NMAX:0]   wr_addr,
    output logic                 sym_done,
    output logic                 done_bank,
    output logic [3:0]           done_lg
);

    localparam int AW = LOG2_NMAX;

    typedef struct packed {
        logic          bank;
        logic [AW-1:0] idx;
        logic [3:0]    lg;
    } wr_state_t;

    wr_state_t  st_d, st_q;
    logic [3:0] lg_raw;
    logic [3:0] lg_cur;
    logic [AW:0]   last_idx;
    logic [AW-1:0] flip_mask;
    logic          at_last;

    always_comb begin
        st_d      = st_q;
        lg_raw    = code_to_log2(size_sel);
        // the size code counts only on the first sample of a symbol
        if (st_q.idx == '0) lg_cur = (lg_raw > 4'(AW)) ? 4'(AW) : lg_raw;
        else                lg_cur = st_q.lg;
        last_idx  = ((AW+1)'(1) << lg_cur) - (AW+1)'(1);
        flip_mask = AW'(1) << (lg_cur - 4'd1);
        at_last   = ({1'b0, st_q.idx} == last_idx);

        in_ready  = !bank_full[st_q.bank];
        wr_en     = in_valid && in_ready;
        // inverting the half bit turns centred carrier order into bin order
        wr_addr   = {st_q.bank, st_q.idx ^ flip_mask};
        sym_done  = wr_en && at_last;
        done_bank = st_q.bank;
        done_lg   = lg_cur;

        if (wr_en) begin
            st_d.lg = lg_cur;
            if (at_last) begin
                st_d.idx  = '0;
                st_d.bank = ~st_q.bank;
            end else begin
                st_d.idx  = st_q.idx + AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Mid-symbol the latched length does not move
    assert_size_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx != '0) |=> $stable(st_q.lg));

endmodule

// File: rtl/ssr_reader.sv
module ssr_reader
    import ssr_pkg::*;
#(
    parameter int LOG2_NMAX = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NBANK-1:0]      bank_full,
    input  logic [NBANK-1:0][3:0] bank_lg,
    input  logic                  out_ready,
    output logic                  rd_en,
    output logic [LOG2_NMAX:0]    rd_addr,
    output logic                  out_valid,
    output logic                  out_sop,
    output logic                  free_en,
    output logic                  free_bank
);

    localparam int AW = LOG2_NMAX;

    typedef struct packed {
        logic          bank;
        logic [AW-1:0] idx;
        logic          vld;
        logic          sop;
    } rd_state_t;

    rd_state_t   st_d, st_q;
    logic [AW:0] last_idx;
    logic        advance;

    always_comb begin
        st_d      = st_q;
        last_idx  = ((AW+1)'(1) << bank_lg[st_q.bank]) - (AW+1)'(1);
        advance   = bank_full[st_q.bank] && (!st_q.vld || out_ready);
        rd_en     = advance;
        rd_addr   = {st_q.bank, st_q.idx};
        free_en   = 1'b0;
        free_bank = st_q.bank;

        if (advance) begin
            st_d.vld = 1'b1;
            st_d.sop = (st_q.idx == '0);
            if ({1'b0, st_q.idx} == last_idx) begin
                st_d.idx  = '0;
                st_d.bank = ~st_q.bank;
                free_en   = 1'b1;
            end else begin
                st_d.idx  = st_q.idx + AW'(1);
            end
        end else if (out_ready) begin
            st_d.vld = 1'b0;
            st_d.sop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_sop   = st_q.sop;

    // Only a bank holding a complete symbol is read
    assert_read_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> bank_full[rd_addr[AW]]);

    // The marker never appears without a valid sample
    assert_sop_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);

endmodule

// File: rtl/ssr_store.sv
module ssr_store #(
    parameter int DW        = 16,
    parameter int LOG2_NMAX = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [LOG2_NMAX:0]   wr_addr,
    input  logic [DW-1:0]        wr_re,
    input  logic [DW-1:0]        wr_im,
    input  logic                 rd_en,
    input  logic [LOG2_NMAX:0]   rd_addr,
    output logic [DW-1:0]        rd_re,
    output logic [DW-1:0]        rd_im
);

    localparam int DEPTH = 2 << LOG2_NMAX;
    localparam int WW    = 2 * DW;

    logic [WW-1:0] mem [DEPTH];
    logic [WW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= {wr_re, wr_im};
    end

    // registered read doubles as the output stage and holds under stall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= mem[rd_addr];
    end

    assign rd_re = rd_q[WW-1:DW];
    assign rd_im = rd_q[DW-1:0];

endmodule

// File: rtl/spec_swap_reorder.sv
module spec_swap_reorder
    import ssr_pkg::*;
#(
    parameter int DW        = 16,
    parameter int LOG2_NMAX = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    size_sel,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_re,
    input  logic [DW-1:0] in_im,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_re,
    output logic [DW-1:0] out_im,
    output logic          out_sop
);

    localparam int AW = LOG2_NMAX;

    logic                  wr_en;
    logic [AW:0]           wr_addr;
    logic                  sym_done;
    logic                  done_bank;
    logic [3:0]            done_lg;
    logic                  rd_en;
    logic [AW:0]           rd_addr;
    logic                  free_en;
    logic                  free_bank;
    logic [NBANK-1:0]      bank_full;
    logic [NBANK-1:0][3:0] bank_lg;

    ssr_writer #(.LOG2_NMAX(LOG2_NMAX)) wr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_sel  (size_sel),
        .in_valid  (in_valid),
        .bank_full (bank_full),
        .in_ready  (in_ready),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .sym_done  (sym_done),
        .done_bank (done_bank),
        .done_lg   (done_lg)
    );

    ssr_bank_flags flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (sym_done),
        .set_bank (done_bank),
        .set_lg   (done_lg),
        .clr_en   (free_en),
        .clr_bank (free_bank),
        .full     (bank_full),
        .bank_lg  (bank_lg)
    );

    ssr_reader #(.LOG2_NMAX(LOG2_NMAX)) rd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_full (bank_full),
        .bank_lg   (bank_lg),
        .out_ready (out_ready),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .free_en   (free_en),
        .free_bank (free_bank)
    );

    ssr_store #(.DW(DW), .LOG2_NMAX(LOG2_NMAX)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_re   (in_re),
        .wr_im   (in_im),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_re   (out_re),
        .rd_im   (out_im)
    );

    // A held output sample stays put
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) &&
                                       $stable(out_im) && $stable(out_sop)));

    // Both banks occupied stops the sink
    assert_sink_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&bank_full) |-> !in_ready);

    // Writes only ever land in a free bank
    assert_write_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !bank_full[wr_addr[AW]]);

endmodule

// File: tb/spec_swap_reorder_tb_top.sv
module spec_swap_reorder_tb_top;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    size_sel = 2'd0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_re = '0;
    logic [DW-1:0] in_im = '0;
    logic          out_valid;
    logic          out_ready;
    logic [DW-1:0] out_re;
    logic [DW-1:0] out_im;
    logic          out_sop;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int stall_cnt = 0;
    int out_cnt = 0;
    int first_cyc = -1;
    int last_cyc = -1;
    int rdy_mode = 0;       // 0 always ready, 1 never, 2 random
    logic [15:0] lfsr = 16'hACE1;

    // entry: {sop, half_tag, re, im}; half_tag 0 = R3 part, 1 = R4 part
    logic [2*DW+1:0] exp_q[$];

    always #5 clk = ~clk;

    spec_swap_reorder #(.DW(DW), .LOG2_NMAX(11)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_sel  (size_sel),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_re    (out_re),
        .out_im    (out_im),
        .out_sop   (out_sop)
    );

    function automatic logic [DW-1:0] mk_re(input int s, input int k);
        return DW'(s * 911 + k * 3 + 1);
    endfunction

    function automatic logic [DW-1:0] mk_im(input int s, input int k);
        return DW'((k * 7) ^ (s * 131));
    endfunction

    function automatic int len_of(input int code);
        case (code)
            0: return 128;
            1: return 512;
            2: return 1024;
            default: return 2048;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // downstream ready driver
    initial begin
        out_ready = 1'b1;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = 1'b0;
                default: out_ready = lfsr[0];
            endcase
        end
    end

    // output monitor, samples mid-cycle
    logic          hold_prev = 1'b0;
    logic [DW-1:0] p_re, p_im;
    logic          p_sop;
    always begin
        @(negedge clk);
        #2;
        cyc++;
        if (rst_n) begin
            if (hold_prev) begin
                checks++;
                if (!(out_valid && out_re == p_re && out_im == p_im && out_sop == p_sop)) begin
                    errors++;
                    $display("FAIL R6 stall hold: actual=%b/%h/%h/%b expected=1/%h/%h/%b",
                             out_valid, out_re, out_im, out_sop, p_re, p_im, p_sop);
                end
            end
            if (out_sop && !out_valid) chk(1'b0, "R5", "sop without valid", 1, 0);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected output sample", 1, 0);
                end else begin
                    logic [2*DW+1:0] e;
                    e = exp_q.pop_front();
                    checks++;
                    if ({out_re, out_im} != e[2*DW-1:0]) begin
                        errors++;
                        $display("FAIL %s data: actual=%h expected=%h",
                                 e[2*DW] ? "R4" : "R3", {out_re, out_im}, e[2*DW-1:0]);
                    end
                    chk(out_sop == e[2*DW+1], "R5", "sop position", int'(out_sop), int'(e[2*DW+1]));
                end
                out_cnt++;
                last_cyc = cyc;
                if (first_cyc < 0) first_cyc = cyc;
            end
            hold_prev = out_valid && !out_ready;
            p_re = out_re; p_im = out_im; p_sop = out_sop;
        end
    end

    // sends one symbol; caller is at a falling edge
    task automatic send_sym(input int code, input int seed,
                            input int chg_at, input int chg_code);
        int n = len_of(code);
        int h = n / 2;
        for (int k = h; k < n; k++)
            exp_q.push_back({(k == h), 1'b0, mk_re(seed, k), mk_im(seed, k)});
        for (int k = 0; k < h; k++)
            exp_q.push_back({1'b0, 1'b1, mk_re(seed, k), mk_im(seed, k)});
        for (int k = 0; k < n; k++) begin
            if (k == 0) size_sel = code[1:0];
            if (k == chg_at) size_sel = chg_code[1:0];
            in_valid = 1'b1;
            in_re = mk_re(seed, k);
            in_im = mk_im(seed, k);
            #2;
            while (!in_ready) begin
                stall_cnt++;
                @(negedge clk);
                #2;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic wait_drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, req, "samples still pending", exp_q.size(), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #2;
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(out_sop == 1'b0, "R1", "out_sop after reset", int'(out_sop), 0);
        @(negedge clk);
    endtask

    task automatic t_sizes();
        for (int c = 0; c < 4; c++) begin
            out_cnt = 0;
            send_sym(c, 10 + c, -1, 0);
            wait_drain("R2");
            chk(out_cnt == len_of(c), "R2", "samples per symbol", out_cnt, len_of(c));
        end
    endtask

    task automatic t_back_to_back();
        rdy_mode = 0;
        @(negedge clk);
        stall_cnt = 0;
        first_cyc = -1;
        out_cnt = 0;
        send_sym(0, 21, -1, 0);
        send_sym(0, 22, -1, 0);
        wait_drain("R8");
        chk(stall_cnt == 0, "R8", "sink stall cycles", stall_cnt, 0);
        chk(last_cyc - first_cyc == 255, "R8", "output span cycles", last_cyc - first_cyc, 255);
        chk(out_cnt == 256, "R8", "samples out", out_cnt, 256);
    endtask

    task automatic t_backpressure();
        rdy_mode = 2;
        out_cnt = 0;
        send_sym(1, 31, -1, 0);
        send_sym(0, 32, -1, 0);
        wait_drain("R6");
        chk(out_cnt == 640, "R6", "samples out under stalls", out_cnt, 640);
        rdy_mode = 0;
        @(negedge clk);
    endtask

    task automatic t_both_full();
        rdy_mode = 1;
        @(negedge clk);
        @(negedge clk);
        send_sym(0, 41, -1, 0);
        send_sym(0, 42, -1, 0);
        repeat (5) @(negedge clk);
        #2;
        chk(in_ready == 1'b0, "R9", "in_ready with both banks full", int'(in_ready), 0);
        chk(out_valid == 1'b1, "R6", "held sample valid", int'(out_valid), 1);
        chk(out_sop == 1'b1, "R5", "held sample is bin 0", int'(out_sop), 1);
        repeat (20) @(negedge clk);
        #2;
        chk(in_ready == 1'b0, "R9", "in_ready still blocked", int'(in_ready), 0);
        @(negedge clk);
        rdy_mode = 0;
        wait_drain("R9");
        #2;
        chk(in_ready == 1'b1, "R9", "in_ready after drain", int'(in_ready), 1);
        @(negedge clk);
    endtask

    task automatic t_mid_change();
        out_cnt = 0;
        send_sym(0, 51, 40, 3);
        wait_drain("R7");
        chk(out_cnt == 128, "R7", "length after mid-symbol code change", out_cnt, 128);
        out_cnt = 0;
        send_sym(0, 52, -1, 0);
        wait_drain("R7");
        chk(out_cnt == 128, "R7", "next symbol length", out_cnt, 128);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sizes();
        t_back_to_back();
        t_backpressure();
        t_both_full();
        t_mid_change();
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule